// File: doc/BRIEF.md
# Ring-Checked Multi-Way Address Translation Lookup

The block translates a 32-bit virtual address by searching several set-associative translation ways in parallel. Each way holds a small array of entries. An entry stores a virtual page tag, a physical page number, an 8-bit address-space identifier and a 4-bit attribute code. A four-byte ring register maps address-space identifiers to protection rings. An entry's ring is the byte position where its identifier appears in that register. The block classifies each request as a success, a miss, a multiple match, a privilege fault or a rights fault. On success it returns the physical address, the granted rights, the cache policy and the ring.

Each request names one of three access kinds: load, store or fetch. Fetches see only the execute right, and loads and stores see only read and write. A write port installs entries in two ways. A direct write targets a way chosen by the caller. A refill takes a page-table word and places it in the way chosen by a round-robin counter. The bus master collects the response one cycle after each request.

Top module: `tlb_xlate`

## Requirements
- R1: After reset `rsp_valid_o` is 0, `rasid_o` reads 0x04030201, and every entry is invalid, so every lookup misses.
- R2: Every cycle with `req_valid_i` high produces exactly one response with `rsp_valid_o` high in the next cycle. No response appears otherwise.
- R3: An entry matches when its stored tag equals vaddr[31:12] at index vaddr[13:12], its identifier is nonzero, and the identifier equals a byte of the ring register. The ring is the lowest byte index holding that identifier. With no match the cause is 1 for a fetch and 2 for a load or store.
- R4: When more than one way matches, the cause is 3 for a fetch and 4 for a load or store.
- R5: When exactly one way matches and its ring is numerically lower than `req_priv_i`, the cause is 5 for a fetch and 6 for a load or store.
- R6: Attribute codes 0 to 11 grant read. Bit 0 adds execute and bit 1 adds write. Bits 3:2 select the cache policy, and `rsp_cache_o` reports 1 for bypass (0), 2 for write-back (1) and 3 for write-through (2). Code 13 grants read and write with `rsp_cache_o` = 4 (isolate). Codes 12, 14 and 15 grant nothing.
- R7: `req_kind_i` is 0 for load, 1 for store and 2 for fetch. A fetch keeps only execute, and a load or store keeps only read and write. A fetch without execute gives cause 7, a load without read gives cause 8, and a store without write gives cause 9.
- R8: Cause 0 means success. In that case `rsp_paddr_o` = {ppn, vaddr[11:0]} and `rsp_rights_o` = {x, w, r} after masking. On any other cause, the physical address, rights, cache and ring outputs are all 0.
- R9: A direct write (`wr_en_i` = 1, `wr_refill_i` = 0) stores tag wr_vaddr[31:12], `wr_ppn_i`, `wr_asid_i` and `wr_attr_i` at way `wr_way_i`, index wr_vaddr[13:12]. It replaces that slot's previous contents.
- R10: On a refill (`wr_en_i` = 1, `wr_refill_i` = 1), a round-robin counter that resets to 0 is incremented modulo the way count, and the new value selects the way. The first refill therefore lands in way 1. The entry takes ppn = pte[31:12] and attribute = pte[3:0]. Its identifier is the ring-register byte selected by pte[5:4].
- R11: A ring-register write (`rasid_we_i`) updates `rasid_o`, and lookups use the new value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rasid_we_i | input | 1 | Ring register write enable |
| rasid_i | input | 32 | New ring register value |
| rasid_o | output | 32 | Current ring register value |
| wr_en_i | input | 1 | Entry write enable |
| wr_refill_i | input | 1 | 1 selects a refill from `wr_pte_i`, 0 selects a direct write |
| wr_way_i | input | 2 | Target way for a direct write |
| wr_vaddr_i | input | 32 | Virtual address of the entry to write |
| wr_ppn_i | input | 20 | Physical page number for a direct write |
| wr_asid_i | input | 8 | Identifier for a direct write |
| wr_attr_i | input | 4 | Attribute code for a direct write |
| wr_pte_i | input | 32 | Page-table word for a refill |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv_i | input | 2 | Privilege index of the requester |
| rsp_valid_o | output | 1 | Response valid |
| rsp_cause_o | output | 4 | Result cause code |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_rights_o | output | 3 | Granted rights {x, w, r} |
| rsp_cache_o | output | 3 | Cache policy code |
| rsp_ring_o | output | 2 | Ring of the matching entry |

## Verification
A lookup's result is due one clock edge after the request: the response registers capture it at the first rising edge after `req_valid_i` rises. Entry writes and ring-register writes are captured at the rising edge that ends their cycle, so the lookup in the next cycle already sees them. The driver changes inputs at falling edges and queues the expected result for each request. A monitor checks `rsp_valid_o` at every falling edge and pops the queue only when a response is present. An early, late, extra or missing response therefore shows up as a mismatch or as a non-empty queue at the end. Way placement by refills is observed indirectly: the bench overwrites a slot, then shows that an entry written earlier now misses while the entries in other ways still match.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int RINGS = 4;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [3:0] {
    C_OK         = 4'd0,
    C_IMISS      = 4'd1,
    C_DMISS      = 4'd2,
    C_IMULTI     = 4'd3,
    C_DMULTI     = 4'd4,
    C_IPRIV      = 4'd5,
    C_DPRIV      = 4'd6,
    C_FETCH_DENY = 4'd7,
    C_LOAD_DENY  = 4'd8,
    C_STORE_DENY = 4'd9
  } cause_e;

  typedef enum logic [2:0] {
    CP_NONE    = 3'd0,
    CP_BYPASS  = 3'd1,
    CP_WB      = 3'd2,
    CP_WT      = 3'd3,
    CP_ISOLATE = 3'd4
  } cache_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;
endpackage

// File: rtl/tlb_attr_dec.sv
module tlb_attr_dec
  import tlb_pkg::*;
(
  input  logic [3:0] attr_i,
  output rights_t    rights_o,
  output cache_e     cache_o
);
  always_comb begin
    rights_o = '0;
    cache_o  = CP_NONE;
    if (attr_i < 4'd12) begin
      rights_o.r = 1'b1;
      rights_o.x = attr_i[0];
      rights_o.w = attr_i[1];
      unique case (attr_i[3:2])
        2'd0:    cache_o = CP_BYPASS;
        2'd1:    cache_o = CP_WB;
        2'd2:    cache_o = CP_WT;
        default: cache_o = CP_NONE;
      endcase
    end else if (attr_i == 4'd13) begin
      rights_o.r = 1'b1;
      rights_o.w = 1'b1;
      cache_o    = CP_ISOLATE;
    end
  end
endmodule

// File: rtl/tlb_ring_find.sv
module tlb_ring_find
  import tlb_pkg::*;
#(
  parameter int ASID_W = 8
) (
  input  logic [RINGS*ASID_W-1:0] rasid_i,
  input  logic [ASID_W-1:0]       asid_i,
  output logic                    found_o,
  output logic [1:0]              ring_o
);
  // scan downward so the lowest matching byte wins
  always_comb begin
    found_o = 1'b0;
    ring_o  = '0;
    for (int i = RINGS - 1; i >= 0; i--) begin
      if (asid_i != '0 && rasid_i[i*ASID_W +: ASID_W] == asid_i) begin
        found_o = 1'b1;
        ring_o  = 2'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [VPN_W-1:0]  wvpn_i,
  input  logic [PPN_W-1:0]  wppn_i,
  input  logic [ASID_W-1:0] wasid_i,
  input  logic [3:0]        wattr_i,
  input  logic [IDX_W-1:0]  ridx_i,
  input  logic [VPN_W-1:0]  rvpn_i,
  output logic              cand_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic [ASID_W-1:0] asid_o,
  output logic [3:0]        attr_o
);
  logic [VPN_W-1:0]  vpn_q  [DEPTH];
  logic [PPN_W-1:0]  ppn_q  [DEPTH];
  logic [ASID_W-1:0] asid_q [DEPTH];
  logic [3:0]        attr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) begin
        vpn_q[e]  <= '0;
        ppn_q[e]  <= '0;
        asid_q[e] <= '0;
        attr_q[e] <= '0;
      end
    end else if (we_i) begin
      vpn_q[widx_i]  <= wvpn_i;
      ppn_q[widx_i]  <= wppn_i;
      asid_q[widx_i] <= wasid_i;
      attr_q[widx_i] <= wattr_i;
    end
  end

  assign cand_o = (asid_q[ridx_i] != '0) && (vpn_q[ridx_i] == rvpn_i);
  assign ppn_o  = ppn_q[ridx_i];
  assign asid_o = asid_q[ridx_i];
  assign attr_o = attr_q[ridx_i];
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int NUM_WAYS  = 4,
  parameter int WAY_DEPTH = 4,
  parameter int ASID_W    = 8,
  localparam int WAY_W    = $clog2(NUM_WAYS),
  localparam int PPN_W    = VA_W - PAGE_BITS,
  localparam int RAS_W    = RINGS * ASID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rasid_we_i,
  input  logic [RAS_W-1:0]  rasid_i,
  output logic [RAS_W-1:0]  rasid_o,
  input  logic              wr_en_i,
  input  logic              wr_refill_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [VA_W-1:0]   wr_vaddr_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [3:0]        wr_attr_i,
  input  logic [VA_W-1:0]   wr_pte_i,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [1:0]        req_kind_i,
  input  logic [1:0]        req_priv_i,
  output logic              rsp_valid_o,
  output logic [3:0]        rsp_cause_o,
  output logic [VA_W-1:0]   rsp_paddr_o,
  output logic [2:0]        rsp_rights_o,
  output logic [2:0]        rsp_cache_o,
  output logic [1:0]        rsp_ring_o
);
  localparam int IDX_W = $clog2(WAY_DEPTH);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int CNT_W = $clog2(NUM_WAYS + 1);

  // ring register
  logic [RAS_W-1:0] rasid_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rasid_q <= 32'h0403_0201;
    else if (rasid_we_i) rasid_q <= rasid_i;
  end
  assign rasid_o = rasid_q;

  // write path: direct or round-robin refill
  logic [WAY_W-1:0]  rr_q, rr_nxt, wr_target;
  logic [PPN_W-1:0]  w_ppn;
  logic [ASID_W-1:0] w_asid;
  logic [3:0]        w_attr;
  logic [IDX_W-1:0]  w_idx;
  logic [VPN_W-1:0]  w_vpn;
  logic              unused_low_bits;

  assign rr_nxt    = (rr_q == WAY_W'(NUM_WAYS - 1)) ? '0 : rr_q + 1'b1;
  assign wr_target = wr_refill_i ? rr_nxt : wr_way_i;
  assign w_ppn     = wr_refill_i ? wr_pte_i[VA_W-1:PAGE_BITS] : wr_ppn_i;
  assign w_attr    = wr_refill_i ? wr_pte_i[3:0] : wr_attr_i;
  assign w_asid    = wr_refill_i ? rasid_q[wr_pte_i[5:4]*ASID_W +: ASID_W] : wr_asid_i;
  assign w_idx     = wr_vaddr_i[PAGE_BITS +: IDX_W];
  assign w_vpn     = wr_vaddr_i[VA_W-1:PAGE_BITS];
  assign unused_low_bits = ^{wr_pte_i[PAGE_BITS-1:6], wr_vaddr_i[PAGE_BITS-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rr_q <= '0;
    else if (wr_en_i && wr_refill_i) rr_q <= rr_nxt;
  end

  // parallel lookup over all ways
  logic [IDX_W-1:0]  r_idx;
  logic [VPN_W-1:0]  r_vpn;
  logic [NUM_WAYS-1:0] cand, found, hit;
  logic [PPN_W-1:0]  way_ppn  [NUM_WAYS];
  logic [ASID_W-1:0] way_asid [NUM_WAYS];
  logic [3:0]        way_attr [NUM_WAYS];
  logic [1:0]        way_ring [NUM_WAYS];

  assign r_idx = req_vaddr_i[PAGE_BITS +: IDX_W];
  assign r_vpn = req_vaddr_i[VA_W-1:PAGE_BITS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlb_way #(
      .VPN_W (VPN_W), .PPN_W (PPN_W), .ASID_W(ASID_W),
      .DEPTH (WAY_DEPTH), .IDX_W(IDX_W)
    ) u_way (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en_i && (wr_target == WAY_W'(w))),
      .widx_i (w_idx),
      .wvpn_i (w_vpn),
      .wppn_i (w_ppn),
      .wasid_i(w_asid),
      .wattr_i(w_attr),
      .ridx_i (r_idx),
      .rvpn_i (r_vpn),
      .cand_o (cand[w]),
      .ppn_o  (way_ppn[w]),
      .asid_o (way_asid[w]),
      .attr_o (way_attr[w])
    );

    tlb_ring_find #(.ASID_W(ASID_W)) u_ring (
      .rasid_i(rasid_q),
      .asid_i (way_asid[w]),
      .found_o(found[w]),
      .ring_o (way_ring[w])
    );

    assign hit[w] = cand[w] & found[w];
  end

  logic [CNT_W-1:0] hit_cnt;
  logic [PPN_W-1:0] sel_ppn;
  logic [3:0]       sel_attr;
  logic [1:0]       sel_ring;

  always_comb begin
    hit_cnt  = '0;
    sel_ppn  = '0;
    sel_attr = '0;
    sel_ring = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hit[w]) begin
        hit_cnt  = hit_cnt + 1'b1;
        sel_ppn  = way_ppn[w];
        sel_attr = way_attr[w];
        sel_ring = way_ring[w];
      end
    end
  end

  rights_t dec_rights, eff_rights;
  cache_e  dec_cache;

  tlb_attr_dec u_dec (
    .attr_i  (sel_attr),
    .rights_o(dec_rights),
    .cache_o (dec_cache)
  );

  logic    is_fetch, granted;
  cause_e  n_cause;

  assign is_fetch = (req_kind_i == ACC_FETCH);

  always_comb begin
    eff_rights = dec_rights;
    if (is_fetch) begin
      eff_rights.r = 1'b0;
      eff_rights.w = 1'b0;
    end else begin
      eff_rights.x = 1'b0;
    end
    unique case (req_kind_i)
      ACC_LOAD:  granted = eff_rights.r;
      ACC_STORE: granted = eff_rights.w;
      ACC_FETCH: granted = eff_rights.x;
      default:   granted = 1'b0;
    endcase

    if (hit_cnt == '0)                  n_cause = is_fetch ? C_IMISS  : C_DMISS;
    else if (hit_cnt > CNT_W'(1))       n_cause = is_fetch ? C_IMULTI : C_DMULTI;
    else if (sel_ring < req_priv_i)     n_cause = is_fetch ? C_IPRIV  : C_DPRIV;
    else if (!granted) begin
      if (is_fetch)                     n_cause = C_FETCH_DENY;
      else if (req_kind_i == ACC_STORE) n_cause = C_STORE_DENY;
      else                              n_cause = C_LOAD_DENY;
    end else                            n_cause = C_OK;
  end

  // registered response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_cause_o  <= '0;
      rsp_paddr_o  <= '0;
      rsp_rights_o <= '0;
      rsp_cache_o  <= '0;
      rsp_ring_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_cause_o <= n_cause;
      if (n_cause == C_OK) begin
        rsp_paddr_o  <= {sel_ppn, req_vaddr_i[PAGE_BITS-1:0]};
        rsp_rights_o <= eff_rights;
        rsp_cache_o  <= dec_cache;
        rsp_ring_o   <= sel_ring;
      end else begin
        rsp_paddr_o  <= '0;
        rsp_rights_o <= '0;
        rsp_cache_o  <= '0;
        rsp_ring_o   <= '0;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [VA_W-1:0] req_vaddr_i,
  input logic [1:0]      req_kind_i,
  input logic            rsp_valid_o,
  input logic [3:0]      rsp_cause_o,
  input logic [VA_W-1:0] rsp_paddr_o,
  input logic [2:0]      rsp_rights_o,
  input logic [2:0]      rsp_cache_o
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R2
  rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  // R8
  fault_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_cause_o != 4'd0)
      |-> (rsp_paddr_o == '0 && rsp_rights_o == '0 && rsp_cache_o == '0));

  // R8
  page_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i) |=> (rsp_cause_o != 4'd0 ||
      rsp_paddr_o[PAGE_BITS-1:0] == $past(req_vaddr_i[PAGE_BITS-1:0])));

  // R7
  fetch_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd2) |=> (rsp_rights_o[1:0] == 2'b00));

  // R7
  data_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i != 2'd2) |=> (rsp_rights_o[2] == 1'b0));

  // R6
  ok_has_rights_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_cause_o == 4'd0) |-> (rsp_rights_o != 3'b000));
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_vaddr_i (req_vaddr_i),
  .req_kind_i  (req_kind_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_cause_o (rsp_cause_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_rights_o(rsp_rights_o),
  .rsp_cache_o (rsp_cache_o)
);

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
  localparam int LD = 0, ST = 1, FE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rasid_we = 1'b0;
  logic [31:0] rasid_in = '0;
  logic [31:0] rasid_out;
  logic        wr_en = 1'b0, wr_refill = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [31:0] wr_vaddr = '0, wr_pte = '0;
  logic [19:0] wr_ppn = '0;
  logic [7:0]  wr_asid = '0;
  logic [3:0]  wr_attr = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0, req_priv = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_cause;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_rights, rsp_cache;
  logic [1:0]  rsp_ring;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .rasid_we_i(rasid_we), .rasid_i(rasid_in), .rasid_o(rasid_out),
    .wr_en_i(wr_en), .wr_refill_i(wr_refill), .wr_way_i(wr_way),
    .wr_vaddr_i(wr_vaddr), .wr_ppn_i(wr_ppn), .wr_asid_i(wr_asid),
    .wr_attr_i(wr_attr), .wr_pte_i(wr_pte),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_kind_i(req_kind), .req_priv_i(req_priv),
    .rsp_valid_o(rsp_valid), .rsp_cause_o(rsp_cause), .rsp_paddr_o(rsp_paddr),
    .rsp_rights_o(rsp_rights), .rsp_cache_o(rsp_cache), .rsp_ring_o(rsp_ring)
  );

  typedef struct {
    logic [3:0]  cause;
    logic [31:0] paddr;
    logic [2:0]  rights;
    logic [2:0]  cache;
    logic [1:0]  ring;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_direct(input logic [1:0] way, input logic [31:0] va,
                           input logic [19:0] ppn, input logic [7:0] asid,
                           input logic [3:0] attr);
    wr_en = 1'b1; wr_refill = 1'b0; wr_way = way; wr_vaddr = va;
    wr_ppn = ppn; wr_asid = asid; wr_attr = attr;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_fill(input logic [31:0] va, input logic [31:0] pte);
    wr_en = 1'b1; wr_refill = 1'b1; wr_vaddr = va; wr_pte = pte;
    @(negedge clk);
    wr_en = 1'b0; wr_refill = 1'b0;
  endtask

  task automatic set_rasid(input logic [31:0] v);
    rasid_we = 1'b1; rasid_in = v;
    @(negedge clk);
    rasid_we = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input int kind, input int priv,
                        input logic [3:0] cause, input logic [31:0] paddr,
                        input logic [2:0] rights, input logic [2:0] cache,
                        input logic [1:0] ring, input string tag);
    exp_t e;
    e.cause = cause; e.paddr = paddr; e.rights = rights;
    e.cache = cache; e.ring = ring; e.tag = tag;
    exp_q.push_back(e);
    req_valid = 1'b1; req_vaddr = va;
    req_kind = 2'(kind); req_priv = 2'(priv);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // failure lookup: all payload expected zero
  task automatic lookup_f(input logic [31:0] va, input int kind, input int priv,
                          input logic [3:0] cause, input string tag);
    lookup(va, kind, priv, cause, 32'h0, 3'b000, 3'd0, 2'd0, tag);
  endtask

  // monitor: scoreboard pop on each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", 32'(rsp_cause), 32'hffff_ffff);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_cause == e.cause,   {e.tag, " cause"},  32'(rsp_cause),  32'(e.cause));
        check(rsp_paddr == e.paddr,   {e.tag, " paddr"},  rsp_paddr,       e.paddr);
        check(rsp_rights == e.rights, {e.tag, " rights"}, 32'(rsp_rights), 32'(e.rights));
        check(rsp_cache == e.cache,   {e.tag, " cache"},  32'(rsp_cache),  32'(e.cache));
        check(rsp_ring == e.ring,     {e.tag, " ring"},   32'(rsp_ring),   32'(e.ring));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    check(rasid_out == 32'h0403_0201, "R1 ring register reset", rasid_out, 32'h0403_0201);
    lookup_f(32'h0000_1000, LD, 0, 4'd2, "R1 empty load miss");
    lookup_f(32'h0000_1000, FE, 0, 4'd1, "R3 empty fetch miss");

    // R9 direct write, R6 attr 4: read, write-back
    wr_direct(2'd0, 32'h1000_2000, 20'h8_0005, 8'h01, 4'd4);
    lookup(32'h1000_2abc, LD, 0, 4'd0, 32'h8000_5abc, 3'b001, 3'd2, 2'd0, "R8 load hit");
    lookup_f(32'h1000_2abc, ST, 0, 4'd9, "R7 store without write");
    lookup_f(32'h1000_2abc, FE, 0, 4'd7, "R7 fetch without execute");
    lookup_f(32'h1000_2abc, LD, 1, 4'd6, "R5 data ring below priv");

    // attr 3: r,x,w bypass; ring 2
    wr_direct(2'd1, 32'h2000_0000, 20'h0_0123, 8'h03, 4'd3);
    lookup(32'h2000_0010, LD, 2, 4'd0, 32'h0012_3010, 3'b011, 3'd1, 2'd2, "R7 data masks exec");
    lookup_f(32'h2000_0010, ST, 3, 4'd6, "R5 priv3 vs ring2");
    lookup(32'h2000_0010, FE, 2, 4'd0, 32'h0012_3010, 3'b100, 3'd1, 2'd2, "R7 fetch masks rw");

    // attr 9: r,x write-through; ring 1
    wr_direct(2'd2, 32'h3000_1000, 20'h0_0777, 8'h02, 4'd9);
    lookup(32'h3000_1004, FE, 1, 4'd0, 32'h0077_7004, 3'b100, 3'd3, 2'd1, "R6 write-through exec");
    lookup_f(32'h3000_1004, ST, 1, 4'd9, "R6 attr9 no write");

    // attr 13: isolate, ring 3
    wr_direct(2'd3, 32'h4000_3000, 20'h0_0abc, 8'h04, 4'd13);
    lookup(32'h4000_3000, ST, 3, 4'd0, 32'h00ab_c000, 3'b011, 3'd4, 2'd3, "R6 isolate store");
    lookup_f(32'h4000_3000, FE, 3, 4'd7, "R6 isolate no exec");

    // attr 12 and 15 grant nothing
    wr_direct(2'd3, 32'h5000_0000, 20'h0_0001, 8'h01, 4'd12);
    lookup_f(32'h5000_0000, LD, 0, 4'd8, "R6 attr12 no read");
    wr_direct(2'd3, 32'h5000_0000, 20'h0_0001, 8'h01, 4'd15);
    lookup_f(32'h5000_0000, LD, 0, 4'd8, "R6 attr15 no read");

    // identifier absent from ring register
    wr_direct(2'd2, 32'h6000_2000, 20'h0_0002, 8'h55, 4'd4);
    lookup_f(32'h6000_2000, LD, 0, 4'd2, "R3 unknown identifier");

    // R4 multi-hit
    wr_direct(2'd1, 32'h1000_2000, 20'h0_0009, 8'h02, 4'd4);
    lookup_f(32'h1000_2abc, LD, 0, 4'd4, "R4 data multi");
    lookup_f(32'h1000_2abc, FE, 0, 4'd3, "R4 fetch multi");
    wr_direct(2'd1, 32'h1000_2000, 20'h0_0009, 8'h00, 4'd4);
    lookup(32'h1000_2abc, LD, 0, 4'd0, 32'h8000_5abc, 3'b001, 3'd2, 2'd0, "R3 zero id no match");

    // R11 ring register update
    set_rasid(32'h0403_0205);
    check(rasid_out == 32'h0403_0205, "R11 ring register readback", rasid_out, 32'h0403_0205);
    lookup_f(32'h1000_2abc, LD, 0, 4'd2, "R11 old id dropped");
    wr_direct(2'd0, 32'h1000_2000, 20'h8_0005, 8'h05, 4'd4);
    lookup(32'h1000_2abc, LD, 0, 4'd0, 32'h8000_5abc, 3'b001, 3'd2, 2'd0, "R11 new id ring0");
    // R3 lowest byte wins: id 2 at bytes 0 and 1 -> ring 0
    set_rasid(32'h0403_0202);
    lookup_f(32'h3000_1004, FE, 1, 4'd5, "R3 lowest byte ring");
    set_rasid(32'h0403_0201);

    // R10 refill placement
    wr_fill(32'h7000_0000, 32'h0004_2024);
    lookup(32'h7000_0008, LD, 2, 4'd0, 32'h0004_2008, 3'b001, 3'd2, 2'd2, "R10 refill ring from pte");
    lookup_f(32'h7000_0008, LD, 3, 4'd6, "R10 refill priv fault");
    lookup_f(32'h2000_0010, LD, 2, 4'd2, "R10 first refill into way1");
    wr_fill(32'h7000_1000, 32'h0004_3014);
    lookup_f(32'h3000_1004, FE, 1, 4'd1, "R10 second refill into way2");
    lookup(32'h7000_1000, LD, 1, 4'd0, 32'h0004_3000, 3'b001, 3'd2, 2'd1, "R10 second refill hit");
    wr_fill(32'h7000_2000, 32'h0004_4004);
    wr_fill(32'h7000_3000, 32'h0004_5004);
    lookup(32'h4000_3000, ST, 3, 4'd0, 32'h00ab_c000, 3'b011, 3'd4, 2'd3, "R10 way3 idx3 kept");
    wr_fill(32'h7100_0000, 32'h0004_6004);
    lookup_f(32'h7000_0008, LD, 2, 4'd2, "R10 wrap back to way1");
    lookup(32'h7100_0000, LD, 0, 4'd0, 32'h0004_6000, 3'b001, 3'd2, 2'd0, "R10 wrapped refill hit");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses arrived", 32'(exp_q.size()), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule